// File: doc/BRIEF.md
# Paged EEPROM Address and Write Controller

This block is the byte-level core of a two-wire serial EEPROM holding 8192 bytes. A bus front end, which is not part of this block, handles bit timing and reports START and STOP conditions and each received byte through one-cycle strobes. For every received byte the controller returns an acknowledge decision. It fetches outgoing read bytes on request from a synchronous single-port array that sits outside the block.

The controller decodes the device header: a fixed device-type nibble, three select bits compared against strapping inputs, and a direction bit. It then takes two address bytes into its internal word address counter. Write data is collected in a 32-byte page buffer, and nothing reaches the array until STOP. On STOP the buffered bytes are programmed during a self-timed write cycle, and a busy output is raised for the length of that cycle. While busy, the controller refuses to acknowledge anything, which lets a host poll for completion.

Reads come in three forms: from the current counter value with no address phase, from a freshly loaded address through a write header followed by a repeated START, and as sequential streams. A hardware write-protect input still lets headers and addresses through but refuses data.

Top module: `eeprom_page_ctl`

## Requirements
- R1: A received header byte is acknowledged only when its bits 7:4 equal 4'b1010 and its bits 3:1 equal `sel_i`. Bit 0 set selects read and clear selects write. After a refused header, every byte is refused until the next START.
- R2: The first address byte supplies address bits 12:8 from its bits 4:0, and its bits 7:5 are ignored. The second address byte supplies bits 7:0. Both address bytes are acknowledged.
- R3: Each accepted write data byte goes into the page buffer at the current address, and only the low 5 address bits then advance. A page write therefore wraps inside its 32-byte aligned page, and bytes past the 32nd replace earlier ones. All array writes of one cycle fall in a single page.
- R4: The array is never written before STOP. After a STOP with buffered data, exactly the buffered locations are programmed, and every other location is left unchanged.
- R5: `busy_o` rises in the cycle after the committing STOP and stays high for exactly WR_CYCLES clock cycles. While it is high, header bytes are not acknowledged.
- R6: With `wp_i` high, the header and address bytes are acknowledged, the first data byte is refused, no write cycle starts, and the array is unchanged.
- R7: A STOP after the address bytes with no data starts no write cycle. It only leaves the counter at the loaded address.
- R8: A read with no address phase returns the byte at the counter, and the counter advances by one for each byte sent. After a page write, the counter holds the address after the last byte written, with the wrap inside the page.
- R9: During reads the full 13-bit counter increments and wraps from 8191 to 0. Read data is valid one cycle after the request.
- R10: A write header with two address bytes, followed by a repeated START and a read header, returns the data at the loaded address.
- R11: After reset, `ack_o`, `busy_o`, `tx_valid_o` and the array strobes are low, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 3 | Device select strapping compared with header bits 3:1 |
| wp_i | input | 1 | Hardware write protect, high refuses data |
| start_i | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_i | input | 1 | One-cycle strobe: STOP seen |
| rx_valid_i | input | 1 | One-cycle strobe: a byte was received |
| rx_data_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the last received byte, valid the cycle after `rx_valid_i` |
| tx_req_i | input | 1 | Request for the next outgoing read byte |
| tx_valid_o | output | 1 | Outgoing byte valid, one cycle after the request |
| tx_data_o | output | 8 | Outgoing read byte |
| busy_o | output | 1 | Self-timed write cycle in progress |
| mem_en_o | output | 1 | Array access enable |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 13 | Array address |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one cycle after an enabled read |

## Verification
The hardest state to reach from the ports is a page buffer in which some slots have been overwritten after the offset wrapped. Programming must then place the last value of each slot at its aligned page address and leave the neighbouring page alone. The stimulus sends forty data bytes from a page boundary and reads the whole page back sequentially against a shadow copy that the bench computes from the wrap rule. A second hard point is the busy window. The bench measures its exact length after one write, and it polls with a header in the middle of another window to confirm the refusal.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam logic [3:0] EPC_DEV_KIND = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_READ,
    ST_SKIP
  } epc_state_e;

  function automatic logic epc_hdr_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == EPC_DEV_KIND) && (b[3:1] == sel);
  endfunction
endpackage

// File: rtl/epc_addr_ctr.sv
module epc_addr_ctr #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              page_inc_i,
  input  logic              seq_inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1'b1)};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (load_i)     addr_q <= load_val_i;
    else if (page_inc_i) addr_q <= page_step(addr_q);
    else if (seq_inc_i)  addr_q <= seq_step(addr_q);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] off_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              drop_i,
  output logic              pending_o,
  output logic              prog_en_o,
  output logic [PAGE_W-1:0] prog_off_o,
  output logic [DATA_W-1:0] prog_data_o
);
  localparam int unsigned PAGE_N = 1 << PAGE_W;
  localparam logic [PAGE_W-1:0] LAST_OFF = PAGE_W'(PAGE_N - 1);

  logic [DATA_W-1:0] slot_q [PAGE_N];
  logic [PAGE_N-1:0] mask_q;
  logic              scan_q;
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      scan_q <= 1'b0;
      idx_q  <= '0;
    end else if (commit_i && (|mask_q) && !scan_q) begin
      scan_q <= 1'b1;
      idx_q  <= '0;
    end else if (drop_i && !scan_q) begin
      mask_q <= '0;
    end else if (scan_q) begin
      mask_q[idx_q] <= 1'b0;
      idx_q         <= PAGE_W'(idx_q + 1'b1);
      if (idx_q == LAST_OFF) scan_q <= 1'b0;
    end else if (wr_i) begin
      mask_q[off_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i && !scan_q) slot_q[off_i] <= data_i;
  end

  assign pending_o   = |mask_q;
  assign prog_en_o   = scan_q && mask_q[idx_q];
  assign prog_off_o  = idx_q;
  assign prog_data_o = slot_q[idx_q];
endmodule

// File: rtl/epc_wr_timer.sv
module epc_wr_timer #(
  parameter int unsigned WR_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned TMR_W = $clog2(WR_CYCLES + 1);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start_i)      cnt_q <= TMR_W'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_q <= TMR_W'(cnt_q - 1'b1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned PAGE_W    = 5,
  parameter int unsigned WR_CYCLES = 600000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel_i,
  input  logic              wp_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              ack_o,
  input  logic              tx_req_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              busy_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int unsigned HI_W  = ADDR_W - 8;
  localparam int unsigned BASE_W = ADDR_W - PAGE_W;

  epc_state_e        st_q;
  logic              ack_q, txv_q;
  logic [HI_W-1:0]   hi_q;
  logic [BASE_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q, load_val;
  logic              ack_now, hdr_ok;
  logic              load_evt, buf_wr, rd_issue, commit_evt, drop_evt;
  logic              pending, prog_en;
  logic [PAGE_W-1:0] prog_off;
  logic [7:0]        prog_data;

  assign hdr_ok   = epc_hdr_hit(rx_data_i, sel_i);
  assign load_val = {hi_q, rx_data_i};

  always_comb begin
    unique case (st_q)
      ST_HDR:        ack_now = hdr_ok;
      ST_AHI,ST_ALO: ack_now = 1'b1;
      ST_WDAT:       ack_now = !wp_i;
      default:       ack_now = 1'b0;
    endcase
  end

  assign load_evt   = rx_valid_i && (st_q == ST_ALO);
  assign buf_wr     = rx_valid_i && (st_q == ST_WDAT) && !wp_i;
  assign rd_issue   = tx_req_i && (st_q == ST_READ);
  assign commit_evt = stop_i && !busy_o && !wp_i && pending;
  assign drop_evt   = stop_i && wp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      txv_q  <= 1'b0;
      hi_q   <= '0;
      base_q <= '0;
    end else begin
      txv_q <= rd_issue;
      if (rx_valid_i) ack_q <= ack_now;
      if (stop_i) begin
        st_q <= ST_IDLE;
      end else if (start_i) begin
        st_q <= busy_o ? ST_SKIP : ST_HDR;
      end else if (rx_valid_i) begin
        unique case (st_q)
          ST_HDR: begin
            if (!hdr_ok)          st_q <= ST_SKIP;
            else if (rx_data_i[0]) st_q <= ST_READ;
            else                  st_q <= ST_AHI;
          end
          ST_AHI: begin
            hi_q <= rx_data_i[HI_W-1:0];
            st_q <= ST_ALO;
          end
          ST_ALO: begin
            base_q <= load_val[ADDR_W-1:PAGE_W];
            st_q   <= ST_WDAT;
          end
          ST_WDAT: if (wp_i) st_q <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  epc_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .load_val_i (load_val),
    .page_inc_i (buf_wr),
    .seq_inc_i  (rd_issue),
    .addr_o     (addr_q)
  );

  epc_page_buf #(.DATA_W(8), .PAGE_W(PAGE_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (buf_wr),
    .off_i       (addr_q[PAGE_W-1:0]),
    .data_i      (rx_data_i),
    .commit_i    (commit_evt),
    .drop_i      (drop_evt),
    .pending_o   (pending),
    .prog_en_o   (prog_en),
    .prog_off_o  (prog_off),
    .prog_data_o (prog_data)
  );

  epc_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (commit_evt),
    .busy_o  (busy_o)
  );

  assign ack_o       = ack_q;
  assign tx_valid_o  = txv_q;
  assign tx_data_o   = mem_rdata_i;
  assign mem_en_o    = prog_en || rd_issue;
  assign mem_we_o    = prog_en;
  assign mem_addr_o  = prog_en ? {base_q, prog_off} : addr_q;
  assign mem_wdata_o = prog_data;
endmodule

// File: rtl/epc_chk.sv
module epc_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              rx_valid_i,
  input logic              ack_o,
  input logic              wp_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              tx_valid_o,
  input logic              rd_issue,
  input logic [ADDR_W-1:0] addr_q
);
  a_r5_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rx_valid_i) |=> !ack_o);

  a_r4_write_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  a_r6_no_cycle_protected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i));

  a_r3_one_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W])));

  a_r9_data_latency: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(rd_issue));

  a_r9_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

bind eeprom_page_ctl epc_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .rx_valid_i (rx_valid_i),
  .ack_o      (ack_o),
  .wp_i       (wp_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .tx_valid_o (tx_valid_o),
  .rd_issue   (rd_issue),
  .addr_q     (addr_q)
);

// File: tb/tb_eeprom_page_ctl.sv
module tb_eeprom_page_ctl;
  localparam int WRC = 40;
  localparam int AW  = 13;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] HW = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] HR = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp = 1'b0, start = 1'b0, stop = 1'b0, rxv = 1'b0, txr = 1'b0;
  logic [7:0] rxd = '0;
  logic ack, txv, busy, men, mwe;
  logic [7:0] txd, mwd, mrd;
  logic [AW-1:0] madr;

  logic [7:0] ram    [1 << AW];
  logic [7:0] shadow [1 << AW];
  int total = 0, bad = 0, wr_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eeprom_page_ctl #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(SEL), .wp_i(wp), .start_i(start), .stop_i(stop),
    .rx_valid_i(rxv), .rx_data_i(rxd), .ack_o(ack), .tx_req_i(txr), .tx_valid_o(txv),
    .tx_data_o(txd), .busy_o(busy), .mem_en_o(men), .mem_we_o(mwe), .mem_addr_o(madr),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd));

  always @(posedge clk) begin
    if (men) begin
      if (mwe) begin ram[madr] <= mwd; wr_cnt <= wr_cnt + 1; end
      else mrd <= ram[madr];
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) + (a >> 8)) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_stop();  stop = 1;  @(negedge clk); stop = 0;  endtask

  task automatic send(input logic [7:0] b, output logic a);
    rxv = 1; rxd = b; @(negedge clk); rxv = 0; a = ack;
  endtask

  task automatic get(output logic [7:0] d);
    txr = 1; @(negedge clk); txr = 0;
    chk(txv === 1'b1, "R9 latency", int'(txv), 1);
    d = txd;
  endtask

  task automatic set_addr(input int a, input logic [7:0] hi_junk);
    logic k;
    pulse_start();
    send(HW, k);                                    chk(k, "R1 header", k, 1);
    send(hi_junk | 8'(a >> 8), k);                  chk(k, "R2 addr hi", k, 1);
    send(8'(a), k);                                 chk(k, "R2 addr lo", k, 1);
  endtask

  task automatic begin_read();
    logic k;
    pulse_start();
    send(HR, k); chk(k, "R1 read header", k, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic k;
    logic [7:0] d;
    int n, w0;
    for (int i = 0; i < (1 << AW); i++) begin ram[i] = pat(i); shadow[i] = pat(i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!ack && !busy && !txv && !men && !mwe, "R11 reset outputs",
        {ack, busy, txv, men, mwe}, 0);
    begin_read();
    get(d); chk(d == shadow[0], "R11 counter zero", d, shadow[0]);
    get(d); chk(d == shadow[1], "R8 current increments", d, shadow[1]);
    pulse_stop();

    // R1 wrong select, wrong kind, bytes refused after
    pulse_start();
    send({4'b1010, 3'b100, 1'b0}, k); chk(!k, "R1 wrong select", k, 0);
    send(8'h00, k);                   chk(!k, "R1 skip after refuse", k, 0);
    pulse_stop();
    pulse_start();
    send({4'b1011, SEL, 1'b1}, k);    chk(!k, "R1 wrong kind", k, 0);
    pulse_stop();

    // R10 random read with junk upper address bits (R2)
    set_addr(16'h0345, 8'hE0);
    begin_read();
    get(d); chk(d == shadow[16'h345], "R10 random read", d, shadow[16'h345]);
    get(d); chk(d == shadow[16'h346], "R2 upper bits ignored", d, shadow[16'h346]);
    pulse_stop();

    // R3/R4 page write across wrap, 6 bytes from offset 28
    set_addr(16'h01FC, 8'h00);
    w0 = wr_cnt;
    for (int j = 0; j < 6; j++) begin
      send(8'hC0 + 8'(j), k); chk(k, "R3 data ack", k, 1);
      shadow[16'h1E0 + ((28 + j) % 32)] = 8'hC0 + 8'(j);
    end
    chk(wr_cnt == w0, "R4 no write before stop", wr_cnt - w0, 0);
    pulse_stop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == WRC, "R5 busy length", n, WRC);
    chk(wr_cnt - w0 == 6, "R4 only buffered bytes", wr_cnt - w0, 6);
    begin_read();
    get(d); chk(d == shadow[16'h1E2], "R8 counter after page wrap", d, shadow[16'h1E2]);
    pulse_stop();
    set_addr(16'h01E0, 8'h00);
    begin_read();
    for (int j = 0; j < 32; j++) begin
      get(d); chk(d == shadow[16'h1E0 + j], "R3 page content", d, shadow[16'h1E0 + j]);
    end
    pulse_stop();

    // R3 overlong page write: 40 bytes from page start
    set_addr(16'h0400, 8'h00);
    for (int j = 0; j < 40; j++) begin
      send(8'h80 + 8'(j), k);
      shadow[16'h400 + (j % 32)] = 8'h80 + 8'(j);
    end
    pulse_stop();
    repeat (5) @(negedge clk);
    // R5 ack polling during busy
    chk(busy, "R5 busy during cycle", busy, 1);
    pulse_start();
    send(HW, k); chk(!k, "R5 poll refused", k, 0);
    pulse_stop();
    wait_idle();
    pulse_start();
    send(HW, k); chk(k, "R5 poll accepted after", k, 1);
    pulse_stop();
    set_addr(16'h0400, 8'h00);
    begin_read();
    for (int j = 0; j < 33; j++) begin
      get(d); chk(d == shadow[16'h400 + j], "R3 overwrite sweep", d, shadow[16'h400 + j]);
    end
    pulse_stop();

    // R6 write protect
    wp = 1;
    set_addr(16'h0900, 8'h00);
    send(8'h11, k); chk(!k, "R6 data refused", k, 0);
    pulse_stop();
    @(negedge clk);
    chk(!busy, "R6 no cycle", busy, 0);
    wp = 0;
    repeat (WRC + 2) @(negedge clk);
    begin_read();
    get(d); chk(d == shadow[16'h900], "R6 array unchanged", d, shadow[16'h900]);
    pulse_stop();

    // R7 address-only write
    w0 = wr_cnt;
    set_addr(16'h0777, 8'h00);
    pulse_stop();
    @(negedge clk);
    chk(!busy, "R7 no cycle", busy, 0);
    begin_read();
    get(d); chk(d == shadow[16'h777], "R7 counter loaded", d, shadow[16'h777]);
    pulse_stop();
    chk(wr_cnt == w0, "R7 no array write", wr_cnt - w0, 0);

    // R9 wrap over the top of the array
    set_addr(16'h1FFF, 8'h00);
    begin_read();
    get(d); chk(d == shadow[16'h1FFF], "R9 last location", d, shadow[16'h1FFF]);
    get(d); chk(d == shadow[0], "R9 wrap to zero", d, shadow[0]);
    pulse_stop();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule